// File: doc/BRIEF.md
# Flag-Producing Arithmetic Logic Unit

This block is the 32-bit execute datapath of a compact 16-bit-encoded RISC core. Each cycle it takes two operands and an operation code and produces a result, a register write-enable and the next values of the four status flags: negative (N), zero (Z), carry (C) and overflow (V). Each flag has its own update enable. The carry-in for the carry-chained operations is the stored C flag. Shifts, memory access, the register file and instruction decode are handled elsewhere.

A thin wrapper holds the four flags in registers. It loads only the flags whose enable is asserted, so a sequence of operations shows the correct carry chaining and flag retention. The arithmetic operations update all four flags. The bitwise operations and multiply update only N and Z. The compare and test operations update flags but never assert the write-enable.

Top module: `alu_flag_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all four stored flags are cleared to 0 at that edge.
- R2: Add (op 0) and compare-negative (op 6) form A+B. N is result bit 31, Z is 1 when the result is zero, C is the unsigned carry out and V is signed overflow.
- R3: Subtract (op 1) and compare (op 5) form A−B. C is 1 when no borrow occurs (A ≥ B unsigned) and V is the signed overflow of the subtraction. N and Z are set as in R2.
- R4: Add-with-carry (op 2) forms A+B+C, where C is the stored carry flag. C is the carry out of the full sum and V is the signed overflow of the full sum.
- R5: Subtract-with-carry (op 3) forms A−B−(1−C). C is 1 when A ≥ B+(1−C) unsigned, and V is the signed overflow of that difference.
- R6: Negate (op 4) forms 0−B and sets all four flags as a subtraction. Negating 0 gives Z=1 and C=1. Negating 0x80000000 gives V=1.
- R7: Compare (5), compare-negative (6) and test (7) never assert `wen_o`. All other defined codes assert it when `op_valid_i` is high.
- R8: AND (8), OR (9), XOR (10), bit-clear A&~B (11), move-not ~B (12) and test A&B (7) update only N and Z. C and V keep their stored values.
- R9: Multiply (13) returns the low 32 bits of A×B and updates only N and Z.
- R10: `flag_en_o` carries the enables as bit 3 N, bit 2 Z, bit 1 C, bit 0 V. Its value is 4'b1111 for ops 0–6 and 4'b1100 for ops 7–13. Each stored flag loads at the clock edge only when its enable is set.
- R11: Codes 14 and 15, and any cycle with `op_valid_i` low, give `wen_o`=0 and `flag_en_o`=0, and leave all stored flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid_i | input | 1 | Operation is executed this cycle |
| op_i | input | 4 | Operation code (see requirements) |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| res_o | output | 32 | Combinational result |
| wen_o | output | 1 | Result register write-enable |
| flag_en_o | output | 4 | Per-flag update enables {N,Z,C,V} |
| flag_n_o | output | 1 | Stored negative flag |
| flag_z_o | output | 1 | Stored zero flag |
| flag_c_o | output | 1 | Stored carry flag |
| flag_v_o | output | 1 | Stored overflow flag |

## Verification
The assertions check on every cycle the properties that hold for any operand values. Compare and test never write. The bitwise and multiply operations leave C and V stable. Stored N and Z always track the previous result. Idle and reserved cycles hold every flag. The flag enable always takes one of its three legal values. The exact carry and overflow values of each arithmetic operation, the stored-carry chaining through add-with-carry and subtract-with-carry, and the multiply result can only be shown by the bench. It compares these against an independent wide-integer model over directed corners and random operands.

// File: rtl/alu_pkg.sv
// Shared types for the flag-producing ALU.
// Assumes a 4-bit operation code; codes 14 and 15 are reserved.
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_ADC = 4'd2,
        OP_SBC = 4'd3,
        OP_NEG = 4'd4,
        OP_CMP = 4'd5,
        OP_CMN = 4'd6,
        OP_TST = 4'd7,
        OP_AND = 4'd8,
        OP_ORR = 4'd9,
        OP_EOR = 4'd10,
        OP_BIC = 4'd11,
        OP_MVN = 4'd12,
        OP_MUL = 4'd13,
        OP_RS0 = 4'd14,
        OP_RS1 = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } alu_flags_t;

endpackage

// File: rtl/alu_addsub.sv
// Adder datapath: maps every arithmetic op onto one WIDTH+1 bit sum
// x + y + ci and derives carry and signed overflow from it.
// Assumes subtraction is done as x + ~b + carry (carry 1 = no borrow).
module alu_addsub
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e            op_i,
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    input  logic               cin_i,
    output logic [WIDTH-1:0]   sum_o,
    output logic               cout_o,
    output logic               ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] x_op;
    logic [WIDTH-1:0] y_op;
    logic             ci;
    logic [WIDTH:0]   wide;

    // Select adder operands and carry-in for the requested operation.
    always_comb begin
        x_op = a_i;
        y_op = b_i;
        ci   = 1'b0;
        case (op_i)
            OP_ADD, OP_CMN: begin
                y_op = b_i;
                ci   = 1'b0;
            end
            OP_SUB, OP_CMP: begin
                y_op = ~b_i;
                ci   = 1'b1;
            end
            OP_ADC: begin
                y_op = b_i;
                ci   = cin_i;
            end
            OP_SBC: begin
                y_op = ~b_i;
                ci   = cin_i;
            end
            OP_NEG: begin
                x_op = '0;
                y_op = ~b_i;
                ci   = 1'b1;
            end
            default: begin
                x_op = a_i;
                y_op = b_i;
                ci   = 1'b0;
            end
        endcase
    end

    // Single carry-propagate sum over both operands and carry-in.
    always_comb begin
        wide = {1'b0, x_op} + {1'b0, y_op} + {{WIDTH{1'b0}}, ci};
    end

    // Carry out and signed overflow of the sum.
    always_comb begin
        sum_o  = wide[MSB:0];
        cout_o = wide[WIDTH];
        ovf_o  = (x_op[MSB] == y_op[MSB]) && (wide[MSB] != x_op[MSB]);
    end

endmodule

// File: rtl/alu_bitwise.sv
// Bitwise and multiply datapath; none of these ops touch carry or overflow.
// Assumes multiply keeps only the low WIDTH bits of the product.
module alu_bitwise
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e            op_i,
    input  logic [WIDTH-1:0]   a_i,
    input  logic [WIDTH-1:0]   b_i,
    output logic [WIDTH-1:0]   res_o
);
    logic [WIDTH-1:0] prod;

    // Truncated product of the two operands.
    always_comb begin
        prod = a_i * b_i;
    end

    // Pick the bitwise or multiply result for the requested operation.
    always_comb begin
        case (op_i)
            OP_TST, OP_AND: res_o = a_i & b_i;
            OP_ORR:         res_o = a_i | b_i;
            OP_EOR:         res_o = a_i ^ b_i;
            OP_BIC:         res_o = a_i & ~b_i;
            OP_MVN:         res_o = ~b_i;
            OP_MUL:         res_o = prod;
            default:        res_o = '0;
        endcase
    end

endmodule

// File: rtl/alu_flag_ctrl.sv
// Classifies the operation code: which datapath drives the result, whether
// the result is written, and which flags are updated.
// Assumes op_valid_i gates every side effect.
module alu_flag_ctrl
    import alu_pkg::*;
(
    input  logic        op_valid_i,
    input  alu_op_e     op_i,
    output logic        sel_arith_o,
    output logic        wen_o,
    output alu_flags_t  en_o
);
    // Decode operation class into write and flag-update enables.
    always_comb begin
        sel_arith_o = 1'b0;
        wen_o       = 1'b0;
        en_o        = '0;
        case (op_i)
            OP_ADD, OP_SUB, OP_ADC, OP_SBC, OP_NEG: begin
                sel_arith_o = 1'b1;
                wen_o       = op_valid_i;
                en_o        = {4{op_valid_i}};
            end
            OP_CMP, OP_CMN: begin
                sel_arith_o = 1'b1;
                en_o        = {4{op_valid_i}};
            end
            OP_TST: begin
                en_o = {op_valid_i, op_valid_i, 2'b00};
            end
            OP_AND, OP_ORR, OP_EOR, OP_BIC, OP_MVN, OP_MUL: begin
                wen_o = op_valid_i;
                en_o  = {op_valid_i, op_valid_i, 2'b00};
            end
            default: begin
                sel_arith_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu_flag_unit.sv
// Top: combinational ALU plus registered N/Z/C/V status flags.
// The stored C feeds the carry-chained ops. Each flag loads only when its
// enable is set. Synchronous active-low reset clears all flags.
module alu_flag_unit
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid_i,
    input  logic [3:0]        op_i,
    input  logic [WIDTH-1:0]  a_i,
    input  logic [WIDTH-1:0]  b_i,
    output logic [WIDTH-1:0]  res_o,
    output logic              wen_o,
    output logic [3:0]        flag_en_o,
    output logic              flag_n_o,
    output logic              flag_z_o,
    output logic              flag_c_o,
    output logic              flag_v_o
);
    localparam int MSB = WIDTH - 1;

    alu_op_e          op_e;
    logic [WIDTH-1:0] arith_res;
    logic [WIDTH-1:0] logic_res;
    logic             arith_c;
    logic             arith_v;
    logic             sel_arith;
    alu_flags_t       upd_en;
    alu_flags_t       nxt_flags;
    alu_flags_t       flags_q;

    // Interpret the raw code as the operation type.
    always_comb begin
        op_e = alu_op_e'(op_i);
    end

    alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .op_i   (op_e),
        .a_i    (a_i),
        .b_i    (b_i),
        .cin_i  (flags_q.c),
        .sum_o  (arith_res),
        .cout_o (arith_c),
        .ovf_o  (arith_v)
    );

    alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .op_i  (op_e),
        .a_i   (a_i),
        .b_i   (b_i),
        .res_o (logic_res)
    );

    alu_flag_ctrl u_ctrl (
        .op_valid_i  (op_valid_i),
        .op_i        (op_e),
        .sel_arith_o (sel_arith),
        .wen_o       (wen_o),
        .en_o        (upd_en)
    );

    // Result mux and next flag values.
    always_comb begin
        res_o       = sel_arith ? arith_res : logic_res;
        nxt_flags.n = res_o[MSB];
        nxt_flags.z = ~|res_o;
        nxt_flags.c = arith_c;
        nxt_flags.v = arith_v;
        flag_en_o   = upd_en;
    end

    // Status flag register with per-flag load enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            if (upd_en.n) flags_q.n <= nxt_flags.n;
            if (upd_en.z) flags_q.z <= nxt_flags.z;
            if (upd_en.c) flags_q.c <= nxt_flags.c;
            if (upd_en.v) flags_q.v <= nxt_flags.v;
        end
    end

    // Drive stored flags to the ports.
    always_comb begin
        flag_n_o = flags_q.n;
        flag_z_o = flags_q.z;
        flag_c_o = flags_q.c;
        flag_v_o = flags_q.v;
    end

    // Reset clears every stored flag.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (flag_n_o == 1'b0 && flag_z_o == 1'b0 &&
                    flag_c_o == 1'b0 && flag_v_o == 1'b0));

    // Compare, compare-negative and test never write.
    assert_cmp_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd5 || op_i == 4'd6 || op_i == 4'd7) |-> !wen_o);

    // Bitwise ops and multiply keep the stored C and V.
    assert_logic_keep_cv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_i >= 4'd7 && op_i <= 4'd13) |=>
            ($stable(flag_c_o) && $stable(flag_v_o)));

    // Stored N and Z follow the previous result for every defined op.
    assert_nz_track_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_i <= 4'd13) |=>
            (flag_n_o == $past(res_o[MSB]) && flag_z_o == ($past(res_o) == '0)));

    // Flag enable takes only its legal shapes.
    assert_enable_shape_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en_o == 4'b0000 || flag_en_o == 4'b1100 || flag_en_o == 4'b1111));

    // Idle or reserved cycles hold all flags and never write.
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid_i || op_i >= 4'd14) |=>
            ($stable(flag_n_o) && $stable(flag_z_o) &&
             $stable(flag_c_o) && $stable(flag_v_o)));

    assert_idle_nowrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid_i || op_i >= 4'd14) |-> (!wen_o && flag_en_o == 4'b0000));

endmodule

// File: tb/sim_alu_flag_unit.sv
// Self-checking bench: directed corners plus seeded random ops against a
// wide-integer reference model of result, write-enable and flags.
module sim_alu_flag_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid_i = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [31:0] res_o;
    logic        wen_o;
    logic [3:0]  flag_en_o;
    logic        flag_n_o, flag_z_o, flag_c_o, flag_v_o;

    int checks = 0;
    int failures = 0;
    logic [3:0] mf = 4'b0000; // model flags {N,Z,C,V}

    alu_flag_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_i(op_i),
        .a_i(a_i), .b_i(b_i), .res_o(res_o), .wen_o(wen_o),
        .flag_en_o(flag_en_o), .flag_n_o(flag_n_o), .flag_z_o(flag_z_o),
        .flag_c_o(flag_c_o), .flag_v_o(flag_v_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic v, input logic [3:0] op);
        if (!v || op >= 4'd14) return "R11";
        case (op)
            4'd0, 4'd6: return "R2";
            4'd1, 4'd5: return "R3";
            4'd2:       return "R4";
            4'd3:       return "R5";
            4'd4:       return "R6";
            4'd13:      return "R9";
            default:    return "R8";
        endcase
    endfunction

    // Runs one operation starting at a negative edge; ends at the next one.
    task automatic run_op(input logic v, input logic [3:0] op,
                          input logic [31:0] a, input logic [31:0] b);
        logic [63:0] wide;
        longint      sres;
        longint      sa, sb;
        logic [31:0] er;
        logic        ew;
        logic [3:0]  ee;
        logic        ec, ev;
        logic        cin;
        string       rq;
        cin = mf[1];
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        er = '0; ec = 1'b0; ev = 1'b0; ew = 1'b0; ee = 4'b0000;
        rq = req_of(v, op);
        case (op)
            4'd0, 4'd6, 4'd2: begin
                logic ci;
                ci = (op == 4'd2) ? cin : 1'b0;
                wide = {32'b0, a} + {32'b0, b} + {63'b0, ci};
                er = wide[31:0];
                ec = wide[32];
                sres = sa + sb + longint'(ci);
                ev = (sres > 64'sd2147483647) || (sres < -64'sd2147483648);
                ee = 4'b1111;
            end
            4'd1, 4'd5, 4'd3, 4'd4: begin
                logic [63:0] ua, sub;
                ua  = (op == 4'd4) ? 64'd0 : {32'b0, a};
                sub = {32'b0, b} + ((op == 4'd3) ? {63'b0, ~cin} : 64'd0);
                er = 32'(ua - sub);
                ec = (ua >= sub);
                sres = ((op == 4'd4) ? 64'sd0 : sa) - sb -
                       ((op == 4'd3) ? longint'(~cin) : 64'sd0);
                ev = (sres > 64'sd2147483647) || (sres < -64'sd2147483648);
                ee = 4'b1111;
            end
            4'd7, 4'd8:  begin er = a & b;  ee = 4'b1100; end
            4'd9:        begin er = a | b;  ee = 4'b1100; end
            4'd10:       begin er = a ^ b;  ee = 4'b1100; end
            4'd11:       begin er = a & ~b; ee = 4'b1100; end
            4'd12:       begin er = ~b;     ee = 4'b1100; end
            4'd13: begin
                wide = {32'b0, a} * {32'b0, b};
                er = wide[31:0];
                ee = 4'b1100;
            end
            default: ee = 4'b0000;
        endcase
        ew = (op <= 4'd13) && !(op == 4'd5 || op == 4'd6 || op == 4'd7);
        if (!v) begin ew = 1'b0; ee = 4'b0000; end
        op_valid_i = v; op_i = op; a_i = a; b_i = b;
        #1;
        if (v && op <= 4'd13) check(rq, "result", res_o, er);
        check((op >= 4'd5 && op <= 4'd7) ? "R7" : rq, "wen", {31'b0, wen_o}, {31'b0, ew});
        check("R10", "flag_en", {28'b0, flag_en_o}, {28'b0, ee});
        if (ee[3]) mf[3] = er[31];
        if (ee[2]) mf[2] = (er == 32'd0);
        if (ee[1]) mf[1] = ec;
        if (ee[0]) mf[0] = ev;
        @(negedge clk);
        check(rq, "flags", {28'b0, flag_n_o, flag_z_o, flag_c_o, flag_v_o}, {28'b0, mf});
    endtask

    function automatic logic [31:0] pick_operand();
        logic [31:0] corners [5];
        corners[0] = 32'h0;
        corners[1] = 32'h1;
        corners[2] = 32'h7FFF_FFFF;
        corners[3] = 32'h8000_0000;
        corners[4] = 32'hFFFF_FFFF;
        if ($urandom_range(3) == 0) return corners[$urandom_range(4)];
        return $urandom();
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1", "reset flags", {28'b0, flag_n_o, flag_z_o, flag_c_o, flag_v_o}, 32'd0);
        rst_n = 1'b1;

        // R2 overflow and carry corners.
        run_op(1'b1, 4'd0, 32'h7FFF_FFFF, 32'h1);
        run_op(1'b1, 4'd0, 32'hFFFF_FFFF, 32'h1);
        // R3 equal, borrow, signed overflow.
        run_op(1'b1, 4'd1, 32'd5, 32'd5);
        run_op(1'b1, 4'd1, 32'd3, 32'd5);
        run_op(1'b1, 4'd1, 32'h8000_0000, 32'd1);
        // R4 carry chaining: set C, then add with carry.
        run_op(1'b1, 4'd0, 32'hFFFF_FFFF, 32'h2);
        run_op(1'b1, 4'd2, 32'hFFFF_FFFE, 32'h1);
        // R5 with C clear: 3 - 5 leaves C=0, then subtract with carry.
        run_op(1'b1, 4'd1, 32'd3, 32'd5);
        run_op(1'b1, 4'd3, 32'd10, 32'd4);
        run_op(1'b1, 4'd3, 32'd0, 32'hFFFF_FFFF);
        // R6 negate corners.
        run_op(1'b1, 4'd4, 32'd0, 32'd0);
        run_op(1'b1, 4'd4, 32'd0, 32'h8000_0000);
        // R7 compare family does not write.
        run_op(1'b1, 4'd5, 32'd9, 32'd9);
        run_op(1'b1, 4'd6, 32'h8000_0000, 32'h8000_0000);
        run_op(1'b1, 4'd7, 32'hF0F0_0000, 32'h0F0F_FFFF);
        // R8 bitwise ops keep C and V (both set by the CMN above).
        run_op(1'b1, 4'd8, 32'hFFFF_0000, 32'h00FF_FF00);
        run_op(1'b1, 4'd9, 32'h8000_0000, 32'h1);
        run_op(1'b1, 4'd10, 32'hAAAA_AAAA, 32'hAAAA_AAAA);
        run_op(1'b1, 4'd11, 32'hFFFF_FFFF, 32'h0000_FFFF);
        run_op(1'b1, 4'd12, 32'd0, 32'd0);
        // R9 multiply truncation.
        run_op(1'b1, 4'd13, 32'h0001_0000, 32'h0001_0000);
        run_op(1'b1, 4'd13, 32'hFFFF_FFFF, 32'd3);
        // R11 idle and reserved codes.
        run_op(1'b0, 4'd0, 32'hFFFF_FFFF, 32'd1);
        run_op(1'b1, 4'd14, 32'd0, 32'd0);
        run_op(1'b1, 4'd15, 32'h8000_0000, 32'h8000_0000);

        // R1 mid-run reset after flags were set.
        run_op(1'b1, 4'd0, 32'hFFFF_FFFF, 32'd1);
        rst_n = 1'b0;
        op_valid_i = 1'b1; op_i = 4'd4; b_i = 32'h8000_0000;
        @(negedge clk);
        mf = 4'b0000;
        check("R1", "reset flags", {28'b0, flag_n_o, flag_z_o, flag_c_o, flag_v_o}, 32'd0);
        rst_n = 1'b1;

        // Random mix of all codes and idle cycles.
        for (int i = 0; i < 600; i++) begin
            logic [3:0] rop;
            logic       rv;
            rop = 4'($urandom_range(15));
            rv  = ($urandom_range(7) != 0);
            run_op(rv, rop, pick_operand(), pick_operand());
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule